// File: doc/BRIEF.md
# Cascadable Timer Channel Pair

Two W-bit timer channels (16 bits by default) sit behind one small register port. Each channel has a counter, a reload value, an upward compare limit, a downward compare limit and a control word. The control word holds a three-bit mode, a direction bit and a source-channel field. In free-running mode a channel steps once per clock. When it reaches the compare limit for its direction, it reloads and raises a compare event.

In chained mode a channel does not step on the clock. It steps only when its selected source channel raises a compare event. The step direction comes from the source, so the two channels act as one 2W-bit synchronous counter. The source drives a dedicated event-and-direction link, so the upper half moves on the same edge as the lower half's wrap. Only a free-running channel drives this link. A chain is therefore at most two channels long, and loops between channels cannot form.

A read of any channel's counter copies every channel's counter into that channel's hold register on the same edge. Software reads one half of a chain through its counter register and then the other half through its hold register. The two halves always belong to the same clock cycle.

Top module: `tpair_timer`

## Requirements
- R1: After synchronous reset, every counter, hold, reload, compare and control register reads zero, `bus_rvalid` is 0 and `cmp_evt` is all zeros.
- R2: The mode field is bits [2:0] of the control register. 3'b001 steps the counter every clock, up when control bit 3 is 0 and down when it is 1. 3'b000 and every code other than 3'b001 and 3'b111 leave the counter unchanged.
- R3: A stepping channel whose counter equals its upward limit while counting up, or its downward limit while counting down, loads its reload value instead of stepping.
- R4: In mode 3'b111, a channel increments by one on each clock in which its source channel takes an upward compare event.
- R5: In mode 3'b111, a channel decrements by one on each clock in which its source channel takes a downward compare event. A pair whose lower half reloads all-ones at zero and upper half does the same tracks a 2W-bit down counter.
- R6: The source field is control bits [4+SRC_W-1:4]. A chained channel that selects itself as its source never steps.
- R7: A channel in mode 3'b111 drives no event onto the link. A channel chained to another chained channel never steps.
- R8: A read strobe to any channel's counter register copies every counter into its own hold register on that edge. `bus_rvalid` rises and `bus_rdata` carries the addressed value one clock after any read strobe.
- R9: A write to a counter register takes effect on that edge and overrides a chained step or reload in the same cycle.
- R10: `cmp_evt[i]` is high for exactly the clock after channel i takes a compare event, in any mode.
- R11: The address is {channel, field}, with field values 0 counter, 1 hold, 2 reload, 3 upward limit, 4 downward limit and 5 control. Control reads back only the mode, direction and source bits, with the upper bits zero. Field values 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | CH_W+3 | {channel, field} register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one clock after the read strobe |
| cmp_evt | output | NCH | Registered compare-event pulse for each channel |

## Verification
The bench runs the pair as a 32-bit counter across the lower-half wrap in both directions and across the all-ones and all-zeros boundaries of the full 32-bit value. A late or missing link would leave the upper half one step behind, and a wrong direction would move it the wrong way. One read is placed on the exact edge where the lower half carries. The read must return the lower half from before the carry, and the hold register must return the upper half from before the carry; if the snapshot were taken after the update, the two halves would come from different cycles. The bench also writes the upper counter on the edge of a carry. It sets up a self-selected source and a chained-to-chained loop, and checks that in each case the counter holds its value instead of stepping.

// File: rtl/tpair_pkg.sv
package tpair_pkg;
  localparam logic [2:0] MODE_IDLE = 3'b000;
  localparam logic [2:0] MODE_RUN  = 3'b001;
  localparam logic [2:0] MODE_CASC = 3'b111;

  localparam int CTRL_DIR_BIT = 3;
  localparam int CTRL_SRC_LSB = 4;

  typedef enum logic [2:0] {
    F_CNT  = 3'd0,
    F_HOLD = 3'd1,
    F_LOAD = 3'd2,
    F_UPL  = 3'd3,
    F_DNL  = 3'd4,
    F_CTRL = 3'd5
  } field_e;
endpackage

// File: rtl/tpair_link.sv
module tpair_link #(
  parameter int NCH   = 2,
  parameter int SRC_W = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NCH-1:0][SRC_W-1:0]   src,
  input  logic [NCH-1:0]              evt_in,
  input  logic [NCH-1:0]              dir_in,
  output logic [NCH-1:0]              cas_evt,
  output logic [NCH-1:0]              cas_dir
);
  for (genvar i = 0; i < NCH; i++) begin : g_sel
    always_comb begin
      cas_evt[i] = 1'b0;
      cas_dir[i] = 1'b0;
      for (int j = 0; j < NCH; j++) begin
        if (j != i && src[i] == SRC_W'(j)) begin
          cas_evt[i] = evt_in[j];
          cas_dir[i] = dir_in[j];
        end
      end
    end

    // R6: a channel never receives an event while it selects itself
    assert_no_self_evt_R6: assert property (@(posedge clk) disable iff (rst)
      (src[i] == SRC_W'(i)) |-> !cas_evt[i]);
  end
endmodule

// File: rtl/tpair_chan.sv
module tpair_chan
  import tpair_pkg::*;
#(
  parameter int W     = 16,
  parameter int IDX   = 0,
  parameter int SRC_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  field_e           wr_field,
  input  logic [W-1:0]     wdata,
  input  logic             snap,
  input  logic             casc_evt,
  input  logic             casc_dir,
  output logic [W-1:0]     cnt_q,
  output logic [W-1:0]     hold_q,
  output logic [W-1:0]     load_q,
  output logic [W-1:0]     upl_q,
  output logic [W-1:0]     dnl_q,
  output logic [2:0]       mode_q,
  output logic             dir_q,
  output logic [SRC_W-1:0] src_q,
  output logic             link_evt,
  output logic             link_dir,
  output logic             evt_q
);
  logic run_mode, casc_mode, adv, step_dn, hit, evt, wr_cnt;

  always_comb begin
    run_mode  = (mode_q == MODE_RUN);
    casc_mode = (mode_q == MODE_CASC);
    adv       = run_mode | (casc_mode & casc_evt);
    step_dn   = casc_mode ? casc_dir : dir_q;
    hit       = step_dn ? (cnt_q == dnl_q) : (cnt_q == upl_q);
    evt       = adv & hit;
    // only a free-running channel feeds the link: bounds a chain to two
    link_evt  = run_mode & (dir_q ? (cnt_q == dnl_q) : (cnt_q == upl_q));
    link_dir  = dir_q;
    wr_cnt    = wr_en && (wr_field == F_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      load_q <= '0;
      upl_q  <= '0;
      dnl_q  <= '0;
      mode_q <= MODE_IDLE;
      dir_q  <= 1'b0;
      src_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (wr_cnt)
        cnt_q <= wdata;
      else if (adv)
        cnt_q <= hit ? load_q : (step_dn ? cnt_q - W'(1) : cnt_q + W'(1));
      if (snap)
        hold_q <= cnt_q;
      if (wr_en) begin
        case (wr_field)
          F_LOAD: load_q <= wdata;
          F_UPL:  upl_q  <= wdata;
          F_DNL:  dnl_q  <= wdata;
          F_CTRL: begin
            mode_q <= wdata[2:0];
            dir_q  <= wdata[CTRL_DIR_BIT];
            src_q  <= wdata[CTRL_SRC_LSB +: SRC_W];
          end
          default: ;
        endcase
      end
      evt_q <= evt;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_mode && !casc_mode && !wr_cnt) |=> cnt_q == $past(cnt_q));

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && hit && !wr_cnt) |=> cnt_q == $past(load_q));

  assert_casc_up_R4: assert property (@(posedge clk) disable iff (rst)
    (casc_mode && casc_evt && !casc_dir && cnt_q != upl_q && !wr_cnt)
      |=> cnt_q == $past(cnt_q) + W'(1));

  assert_casc_dn_R5: assert property (@(posedge clk) disable iff (rst)
    (casc_mode && casc_evt && casc_dir && cnt_q != dnl_q && !wr_cnt)
      |=> cnt_q == $past(cnt_q) - W'(1));

  assert_self_src_R6: assert property (@(posedge clk) disable iff (rst)
    (casc_mode && src_q == SRC_W'(IDX) && !wr_cnt) |=> cnt_q == $past(cnt_q));

  assert_casc_silent_R7: assert property (@(posedge clk) disable iff (rst)
    casc_mode |-> !link_evt);

  assert_snap_R8: assert property (@(posedge clk) disable iff (rst)
    snap |=> hold_q == $past(cnt_q));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(wdata));

  assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    evt |=> evt_q);
endmodule

// File: rtl/tpair_timer.sv
module tpair_timer
  import tpair_pkg::*;
#(
  parameter  int W      = 16,
  parameter  int NCH    = 2,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SRC_W  = CH_W,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_rvalid,
  output logic [NCH-1:0]    cmp_evt
);
  logic [W-1:0]            cnt_a  [NCH];
  logic [W-1:0]            hold_a [NCH];
  logic [W-1:0]            load_a [NCH];
  logic [W-1:0]            upl_a  [NCH];
  logic [W-1:0]            dnl_a  [NCH];
  logic [2:0]              mode_a [NCH];
  logic [NCH-1:0]          dir_a;
  logic [NCH-1:0][SRC_W-1:0] src_a;
  logic [NCH-1:0]          lnk_evt, lnk_dir, cas_evt, cas_dir, evt_q;

  field_e          fsel;
  logic [CH_W-1:0] ch_sel;
  logic            snap;
  logic [W-1:0]    rdata_d;

  assign fsel   = field_e'(bus_addr[2:0]);
  assign ch_sel = bus_addr[3 +: CH_W];
  assign snap   = bus_rd && (fsel == F_CNT);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tpair_chan #(.W(W), .IDX(g), .SRC_W(SRC_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_wr && ch_sel == CH_W'(g)),
      .wr_field (fsel),
      .wdata    (bus_wdata),
      .snap     (snap),
      .casc_evt (cas_evt[g]),
      .casc_dir (cas_dir[g]),
      .cnt_q    (cnt_a[g]),
      .hold_q   (hold_a[g]),
      .load_q   (load_a[g]),
      .upl_q    (upl_a[g]),
      .dnl_q    (dnl_a[g]),
      .mode_q   (mode_a[g]),
      .dir_q    (dir_a[g]),
      .src_q    (src_a[g]),
      .link_evt (lnk_evt[g]),
      .link_dir (lnk_dir[g]),
      .evt_q    (evt_q[g])
    );
  end

  tpair_link #(.NCH(NCH), .SRC_W(SRC_W)) u_link (
    .clk     (clk),
    .rst     (rst),
    .src     (src_a),
    .evt_in  (lnk_evt),
    .dir_in  (lnk_dir),
    .cas_evt (cas_evt),
    .cas_dir (cas_dir)
  );

  assign cmp_evt = evt_q;

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel == CH_W'(i)) begin
        case (fsel)
          F_CNT:   rdata_d = cnt_a[i];
          F_HOLD:  rdata_d = hold_a[i];
          F_LOAD:  rdata_d = load_a[i];
          F_UPL:   rdata_d = upl_a[i];
          F_DNL:   rdata_d = dnl_a[i];
          F_CTRL:  rdata_d = W'({src_a[i], dir_a[i], mode_a[i]});
          default: rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd)
        bus_rdata <= rdata_d;
    end
  end

  assert_rvalid_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));

  assert_rvalid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/test_tpair_timer.sv
module test_tpair_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NCH = 2;

  localparam int FC = 0, FH = 1, FL = 2, FU = 3, FD = 4, FK = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          bus_rvalid;
  logic [NCH-1:0] cmp_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpair_timer #(.W(W), .NCH(NCH)) i_tpair_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cmp_evt(cmp_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(input int ch, input int f, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = 4'(ch * 8 + f); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int f, input logic [W-1:0] exp, input string req);
    bus_rd = 1'b1; bus_addr = 4'(ch * 8 + f);
    @(negedge clk);
    bus_rd = 1'b0;
    chk({req, " rvalid"}, 32'(bus_rvalid), 32'd1);
    chk(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rvalid", 32'(bus_rvalid), 32'd0);
    chk("R1 cmp_evt", 32'(cmp_evt), 32'd0);
    rd(0, FC, 16'h0, "R1 cnt0");
    rd(1, FK, 16'h0, "R1 ctrl1");
    rd(1, FL, 16'h0, "R1 load1");
    rd(0, FH, 16'h0, "R1 hold0");
  endtask

  task automatic t_primary;
    // counts = idle cycles + 1 (stop write edge still counts)
    wr(0, FC, 16'd10); wr(0, FK, 16'h0001); idle(4); wr(0, FK, 16'h0000);
    rd(0, FC, 16'd15, "R2 run up");
    wr(0, FC, 16'd10); wr(0, FK, 16'h0009); idle(4); wr(0, FK, 16'h0000);
    rd(0, FC, 16'd5, "R2 run down");
    wr(0, FK, 16'h0002); idle(4);
    rd(0, FC, 16'd5, "R2 unlisted mode holds");
    wr(0, FK, 16'h0000);
  endtask

  task automatic t_compare;
    wr(0, FC, 16'd7); wr(0, FU, 16'd7); wr(0, FL, 16'd5);
    wr(0, FK, 16'h0001);
    @(negedge clk);
    chk("R10 evt pulse", 32'(cmp_evt[0]), 32'd1);
    wr(0, FK, 16'h0000);
    chk("R10 evt one cycle", 32'(cmp_evt[0]), 32'd0);
    rd(0, FC, 16'd6, "R3 up reload");
    wr(0, FC, 16'd3); wr(0, FD, 16'd3); wr(0, FL, 16'd9);
    wr(0, FK, 16'h0009); @(negedge clk); wr(0, FK, 16'h0000);
    rd(0, FC, 16'd8, "R3 down reload");
  endtask

  task automatic set_pair(input logic [W-1:0] ld, input logic [31:0] v);
    wr(0, FL, ld); wr(1, FL, ld);
    wr(0, FU, 16'hFFFF); wr(1, FU, 16'hFFFF);
    wr(0, FD, 16'h0000); wr(1, FD, 16'h0000);
    wr(1, FK, 16'h0007);
    wr(0, FC, v[15:0]); wr(1, FC, v[31:16]);
  endtask

  task automatic run_pair(input bit down, input int k);
    wr(0, FK, down ? 16'h0009 : 16'h0001); idle(k); wr(0, FK, 16'h0000);
  endtask

  task automatic t_cascade;
    logic [31:0] m;
    m = 32'h1234_FFFC;
    set_pair(16'h0000, m); run_pair(1'b0, 5); m = m + 32'd6;
    rd(0, FC, m[15:0], "R4 low half up");
    rd(1, FH, m[31:16], "R8 high hold after low read");
    rd(1, FC, m[31:16], "R4 high half up");
    wr(0, FL, 16'hFFFF); wr(1, FL, 16'hFFFF);
    run_pair(1'b1, 5); m = m - 32'd6;
    rd(1, FC, m[31:16], "R5 high half down");
    rd(0, FC, m[15:0], "R5 low half down");
    m = 32'hFFFF_FFFE;
    set_pair(16'h0000, m); run_pair(1'b0, 2); m = m + 32'd3;
    rd(0, FC, m[15:0], "R4 32-bit wrap low");
    rd(1, FC, m[31:16], "R4 32-bit wrap high");
    m = 32'h0000_0001;
    set_pair(16'hFFFF, m); run_pair(1'b1, 2); m = m - 32'd3;
    rd(0, FC, m[15:0], "R5 32-bit wrap low");
    rd(1, FC, m[31:16], "R5 32-bit wrap high");
  endtask

  task automatic t_coherent;
    set_pair(16'h0000, 32'h00AA_FFFD);
    wr(0, FK, 16'h0001);
    idle(2);
    rd(0, FC, 16'hFFFF, "R8 read on carry edge");
    wr(0, FK, 16'h0000);
    rd(1, FH, 16'h00AA, "R8 high hold pre-carry");
    rd(0, FH, 16'hFFFF, "R8 low hold");
    rd(1, FC, 16'h00AB, "R4 high after carry");
  endtask

  task automatic t_write_wins;
    set_pair(16'h0000, 32'h0400_FFFE);
    wr(0, FK, 16'h0001); idle(1);
    wr(1, FC, 16'h0500);
    wr(0, FK, 16'h0000);
    rd(1, FC, 16'h0500, "R9 write beats carry");
    rd(0, FC, 16'h0001, "R9 low half");
  endtask

  task automatic t_self_and_loop;
    wr(1, FK, 16'h0017);
    wr(0, FC, 16'hFFFE); run_pair(1'b0, 4);
    rd(0, FC, 16'h0003, "R6 source still runs");
    rd(1, FC, 16'h0500, "R6 self source holds");
    wr(0, FK, 16'h0017); wr(1, FK, 16'h0007); idle(5);
    rd(0, FC, 16'h0003, "R7 loop low holds");
    rd(1, FC, 16'h0500, "R7 loop high holds");
    wr(0, FK, 16'h0000); wr(1, FK, 16'h0000);
  endtask

  task automatic t_regmap;
    wr(1, FL, 16'hA5A5); wr(1, FU, 16'h1357); wr(1, FD, 16'h2468);
    rd(1, FL, 16'hA5A5, "R11 reload");
    rd(1, FU, 16'h1357, "R11 up limit");
    rd(1, FD, 16'h2468, "R11 down limit");
    wr(0, FK, 16'hFFFF);
    rd(0, FK, 16'h001F, "R11 control bits");
    rd(0, 6, 16'h0000, "R11 field 6");
    rd(1, 7, 16'h0000, "R11 field 7");
    wr(0, FK, 16'h0000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_primary();
    t_compare();
    t_cascade();
    t_coherent();
    t_write_wins();
    t_self_and_loop();
    t_regmap();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule